// File: doc/BRIEF.md
# Receive Byte Queue with Character Timeout

This block sits between the serial deserializer and the register interface of a 16550-style UART receiver. It takes each received byte, or a break indication, and either queues it in a 16-entry byte FIFO or, when the queue is switched off, places it in a single holding register. It drives the line status bits that software reads: data-ready, break and overrun.

It also drives two interrupt sources. The first is a trigger flag, raised when the number of queued bytes reaches a programmable level. The second is a character-timeout flag, raised when bytes have waited unread for four character times. The register interface drives the read strobe, the queue enable, a receiver reset pulse, the trigger-level select and the length of one character in clock cycles. A separate strobe marks a read of the line status register.

Top module: `rxq_top`

## Requirements
- R1: After synchronous reset, count, data_ready, brk, overrun, trig_hit, timeout_pend and rd_data are all zero.
- R2: trig_sel encodes the trigger level as 2'b00 = 1 byte, 2'b01 = 4, 2'b10 = 8, 2'b11 = 14. In queue mode (fifo_en = 1), trig_hit is high exactly when data_ready is set and count is at least the selected level. In single-register mode, trig_hit equals data_ready.
- R3: In queue mode, bytes are returned in arrival order. Each rd_strobe pops one byte, which appears on rd_data the cycle after the strobe. count gives the number of stored bytes (0 to 16), and count is nonzero only while data_ready is set.
- R4: A byte that arrives while the queue holds 16 bytes, with no read in the same cycle, is discarded. The stored bytes and the count do not change, and overrun is set.
- R5: A read of an empty queue returns 0 on rd_data. A read that leaves the queue empty clears data_ready.
- R6: In single-register mode (fifo_en = 0), each byte replaces the holding register and sets data_ready. If data_ready was already set and no read happens in that cycle, overrun is set. A read returns the holding register and clears data_ready. count stays 0.
- R7: A break strobe stores a zero byte and sets both brk and data_ready. brk is cleared by a read that leaves the receiver empty.
- R8: In queue mode, each arrival reloads a timer with 4*char_time cycles, and so does a read that leaves bytes behind. timeout_pend rises 4*char_time clock edges after the last reload if the queue is still not empty. Any read clears timeout_pend.
- R9: A rx_reset pulse, or any change of fifo_en, empties the queue and clears data_ready, brk, the timer and timeout_pend. The flush leaves overrun as it was.
- R10: An lsr_rd strobe clears overrun and brk, unless a new overrun or break is set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: rx_data holds a received byte |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | One-cycle strobe: a break was received |
| rd_strobe | input | 1 | Receive data register read |
| lsr_rd | input | 1 | Line status register read |
| fifo_en | input | 1 | Queue mode enable |
| rx_reset | input | 1 | Receiver flush pulse |
| trig_sel | input | 2 | Trigger level select |
| char_time | input | 16 | Length of one character in clock cycles (0 disables the timer) |
| rd_data | output | 8 | Byte returned by the last read |
| count | output | 5 | Number of bytes in the queue |
| data_ready | output | 1 | Received data available |
| brk | output | 1 | Break received |
| overrun | output | 1 | A byte was lost |
| trig_hit | output | 1 | Trigger level reached |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
Each of the four trigger levels is swept with queue depths from 1 to 15. This shows whether a level is decoded wrongly or whether the comparison is off by one. A run of 16 distinct bytes followed by a seventeenth separates a drop on overflow from an overwrite, and the read-back order shows a pointer fault. Timeout runs sample the cycle just before and the cycle at expiry, both after an arrival and after a partial read. Single-register, break, flush and status-clear sequences each check flags that a wrong priority would leave set or clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic dr;
        logic brk;
        logic ovr;
        logic pend;
    } rxq_flags_t;

    function automatic logic [4:0] trig_level(input trig_sel_e sel);
        case (sel)
            TRIG_1:  return 5'd1;
            TRIG_4:  return 5'd4;
            TRIG_8:  return 5'd8;
            default: return 5'd14;
        endcase
    endfunction
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign head  = mem[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int CTW = 16,
    localparam int TW = CTW + 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stop,
    input  logic           load,
    input  logic [CTW-1:0] char_time,
    output logic           expire
);
    logic [TW-1:0] cnt;

    assign expire = (cnt == TW'(1)) && !load && !stop;

    always_ff @(posedge clk) begin
        if (rst || stop)      cnt <= '0;
        else if (load)        cnt <= {char_time, 2'b00};
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
    parameter int CW = 5
) (
    input  logic          fifo_en,
    input  logic          dr,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] count,
    output logic          trig_hit
);
    import rxq_pkg::*;
    logic [4:0] lvl;

    always_comb begin
        lvl = trig_level(trig_sel_e'(trig_sel));
        if (fifo_en) trig_hit = dr && ({{(CW < 5 ? 0 : 1){1'b0}}, count} >= {{(CW < 5 ? 0 : 1){1'b0}}, CW'(lvl)});
        else         trig_hit = dr;
    end
endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
    parameter int DEPTH = 16,
    parameter int CTW   = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rx_valid,
    input  logic [7:0]     rx_data,
    input  logic           rx_break,
    input  logic           rd_strobe,
    input  logic           lsr_rd,
    input  logic           fifo_en,
    input  logic           rx_reset,
    input  logic [1:0]     trig_sel,
    input  logic [CTW-1:0] char_time,
    output logic [7:0]     rd_data,
    output logic [CW-1:0]  count,
    output logic           data_ready,
    output logic           brk,
    output logic           overrun,
    output logic           trig_hit,
    output logic           timeout_pend
);
    import rxq_pkg::*;

    rxq_flags_t fl;
    logic       en_q;
    logic [7:0] hold, rd_q, head, in_byte;
    logic       flush, rx_any, push_req, push_ok, pop, drop, full, empty;
    logic       remain, t_load, t_stop, expire;
    logic [CW-1:0] next_cnt;

    assign flush    = rx_reset || (fifo_en != en_q);
    assign rx_any   = (rx_valid || rx_break) && !flush;
    assign in_byte  = rx_break ? 8'h00 : rx_data;
    assign push_req = rx_any && fifo_en;
    assign pop      = rd_strobe && fifo_en && !flush && !empty;
    assign push_ok  = push_req && (!full || pop);
    assign drop     = push_req && !push_ok;
    assign next_cnt = count + CW'(push_ok) - CW'(pop);
    assign remain   = fifo_en && (next_cnt != '0);
    assign t_stop   = flush || !fifo_en || (rd_strobe && !remain);
    assign t_load   = push_req || (rd_strobe && remain);

    rxq_ring #(.DEPTH(DEPTH), .DW(BYTE_W)) u_ring (
        .clk(clk), .rst(rst), .flush(flush), .push(push_ok), .pop(pop),
        .wdata(in_byte), .head(head), .count(count), .full(full), .empty(empty)
    );

    rxq_timer #(.CTW(CTW)) u_timer (
        .clk(clk), .rst(rst), .stop(t_stop), .load(t_load),
        .char_time(char_time), .expire(expire)
    );

    rxq_trigger #(.CW(CW)) u_trig (
        .fifo_en(fifo_en), .dr(fl.dr), .trig_sel(trig_sel),
        .count(count), .trig_hit(trig_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fl   <= '0;
            en_q <= 1'b0;
            hold <= '0;
            rd_q <= '0;
        end else begin
            en_q <= fifo_en;
            if (rd_strobe) begin
                if (flush)        rd_q <= '0;
                else if (fifo_en) rd_q <= empty ? 8'h00 : head;
                else              rd_q <= hold;
            end
            if (rx_any && !fifo_en) hold <= in_byte;

            if (rx_any)                         fl.dr <= 1'b1;
            else if (flush || (rd_strobe && !remain)) fl.dr <= 1'b0;

            if (rx_break && !flush)             fl.brk <= 1'b1;
            else if (flush || lsr_rd || (rd_strobe && !remain)) fl.brk <= 1'b0;

            if (drop || (rx_any && !fifo_en && fl.dr && !rd_strobe)) fl.ovr <= 1'b1;
            else if (lsr_rd)                    fl.ovr <= 1'b0;

            if (flush || rd_strobe || !fifo_en) fl.pend <= 1'b0;
            else if (expire && count != '0)     fl.pend <= 1'b1;
        end
    end

    assign rd_data      = rd_q;
    assign data_ready   = fl.dr;
    assign brk          = fl.brk;
    assign overrun      = fl.ovr;
    assign timeout_pend = fl.pend;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          rx_break,
    input logic          rd_strobe,
    input logic          fifo_en,
    input logic          flush,
    input logic [CW-1:0] count,
    input logic          data_ready,
    input logic          brk,
    input logic          overrun,
    input logic          timeout_pend
);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_count_needs_dr_R3: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> data_ready);

    assert_drop_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && !flush && count == CW'(DEPTH) && (rx_valid || rx_break) && !rd_strobe)
        |=> (overrun && $stable(count)));

    assert_break_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_break && !flush) |=> (brk && data_ready));

    assert_read_clears_pend_R8: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> !timeout_pend);

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && !data_ready && !brk && !timeout_pend));
endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_break(rx_break),
    .rd_strobe(rd_strobe), .fifo_en(fifo_en), .flush(flush), .count(count),
    .data_ready(data_ready), .brk(brk), .overrun(overrun),
    .timeout_pend(timeout_pend)
);

// File: tb/rxq_top_tb.sv
`timescale 1ns/1ps
module rxq_top_tb;
    localparam int DEPTH = 16;
    localparam int CTW   = 16;
    localparam int CW    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, rx_break = 0, rd_strobe = 0, lsr_rd = 0;
    logic fifo_en = 0, rx_reset = 0;
    logic [7:0] rx_data = '0;
    logic [1:0] trig_sel = '0;
    logic [CTW-1:0] char_time = 16'd1000;
    logic [7:0] rd_data;
    logic [CW-1:0] count;
    logic data_ready, brk, overrun, trig_hit, timeout_pend;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rxq_top #(.DEPTH(DEPTH), .CTW(CTW)) u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rd_strobe(rd_strobe), .lsr_rd(lsr_rd),
        .fifo_en(fifo_en), .rx_reset(rx_reset), .trig_sel(trig_sel),
        .char_time(char_time), .rd_data(rd_data), .count(count),
        .data_ready(data_ready), .brk(brk), .overrun(overrun),
        .trig_hit(trig_hit), .timeout_pend(timeout_pend)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        rx_data = b; rx_valid = 1; tick(); rx_valid = 0;
    endtask

    task automatic brk_in();
        rx_break = 1; tick(); rx_break = 0;
    endtask

    task automatic rd();
        rd_strobe = 1; tick(); rd_strobe = 0;
    endtask

    task automatic lsr();
        lsr_rd = 1; tick(); lsr_rd = 0;
    endtask

    task automatic flush_rx();
        rx_reset = 1; tick(); rx_reset = 0;
    endtask

    function automatic int level_of(input int s);
        case (s)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 data_ready", data_ready, 0);
        chk("R1 brk", brk, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 trig_hit", trig_hit, 0);
        chk("R1 timeout_pend", timeout_pend, 0);
        chk("R1 rd_data", rd_data, 0);

        fifo_en = 1; tick();

        // R2 sweep of every trigger level against every depth 1..15
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            flush_rx();
            for (int n = 1; n < DEPTH; n++) begin
                push(8'(n));
                chk("R2 trig_hit", trig_hit, (n >= level_of(s)) ? 1 : 0);
            end
        end
        flush_rx();
        chk("R9 rx_reset count", count, 0);
        chk("R9 rx_reset dr", data_ready, 0);

        // R3 order / R4 overflow drop
        for (int i = 0; i < DEPTH; i++) begin
            push(8'((i * 13 + 7) & 255));
            chk("R3 count rising", count, i + 1);
        end
        push(8'hEE);
        chk("R4 count kept", count, DEPTH);
        chk("R4 overrun", overrun, 1);
        lsr();
        chk("R10 overrun cleared", overrun, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd();
            chk("R3 order", rd_data, (i * 13 + 7) & 255);
            chk("R3 count falling", count, DEPTH - 1 - i);
        end
        chk("R5 dr after last", data_ready, 0);
        rd();
        chk("R5 empty read data", rd_data, 0);
        chk("R5 empty read dr", data_ready, 0);

        // R7 break
        push(8'h41);
        brk_in();
        chk("R7 brk", brk, 1);
        chk("R7 dr", data_ready, 1);
        chk("R7 count", count, 2);
        rd();
        chk("R7 first byte", rd_data, 8'h41);
        chk("R7 brk held", brk, 1);
        rd();
        chk("R7 null byte", rd_data, 0);
        chk("R7 brk cleared", brk, 0);
        chk("R7 dr cleared", data_ready, 0);
        brk_in();
        lsr();
        chk("R10 brk cleared by lsr", brk, 0);
        chk("R10 dr kept", data_ready, 1);
        rd();

        // R8 timeout, char_time = 5 -> 20 cycles
        char_time = 16'd5;
        push(8'hA1);
        push(8'hA2);
        repeat (19) tick();
        chk("R8 before expiry", timeout_pend, 0);
        tick();
        chk("R8 at expiry", timeout_pend, 1);
        rd();
        chk("R8 read clears", timeout_pend, 0);
        chk("R8 read data", rd_data, 8'hA1);
        repeat (19) tick();
        chk("R8 restart before", timeout_pend, 0);
        tick();
        chk("R8 restart expiry", timeout_pend, 1);
        rd();
        repeat (25) tick();
        chk("R8 empty no timeout", timeout_pend, 0);
        char_time = 16'd1000;

        // R9 enable change flush
        push(8'h01); push(8'h02); push(8'h03);
        fifo_en = 0; tick();
        chk("R9 mode change count", count, 0);
        chk("R9 mode change dr", data_ready, 0);

        // R6 single-register mode
        push(8'h11);
        chk("R6 dr", data_ready, 1);
        chk("R6 count zero", count, 0);
        chk("R2 trig single mode", trig_hit, 1);
        push(8'h22);
        chk("R6 overrun", overrun, 1);
        rd();
        chk("R6 latest byte", rd_data, 8'h22);
        chk("R6 dr cleared", data_ready, 0);
        lsr();
        chk("R10 overrun cleared", overrun, 0);

        // R9 flush keeps overrun
        fifo_en = 1; tick();
        for (int i = 0; i <= DEPTH; i++) push(8'(i));
        brk_in();
        chk("R9 pre overrun", overrun, 1);
        flush_rx();
        chk("R9 count", count, 0);
        chk("R9 brk", brk, 0);
        chk("R9 dr", data_ready, 0);
        chk("R9 overrun kept", overrun, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule